// File: doc/BRIEF.md
# Blocking Token Channel End

This block is one end of a full-duplex, point-to-point channel between hardware threads. Each direction has its own token buffer. A token is an 8-bit payload plus a flag that marks it as either a data token or a control token. On the thread side, a thread issues output requests to send a single token or a whole 32-bit word, and input requests to take a single token or a whole word. On the link side, tokens leave and arrive through plain valid/ready handshakes.

A request that cannot complete at once does not fail. The requesting thread is held in a paused state instead. The block keeps the request and finishes it whole as soon as the buffer has room, or as soon as enough tokens have arrived. It then signals with a one-cycle resume pulse. A word input that would run into a control token reports an error, and it leaves the receive buffer untouched.

Top module: `token_chan_end`

## Requirements
- R1: After reset, tx_valid, out_done, out_paused, out_resume, in_done, in_paused, in_resume and in_err are all low, and rx_ready is high.
- R2: An out_req with out_word=0 enqueues one token (control flag out_ctrl, payload out_data[7:0]). If there is room, out_done is high for exactly the cycle after the request. Tokens leave on tx_ctrl/tx_data in the order they were enqueued.
- R3: An out_req with out_word=1 enqueues four data tokens (flag 0): out_data[31:24] first, then [23:16], then [15:8], then [7:0] last.
- R4: A token crosses the link only in a cycle where valid and ready are both high. While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_ctrl hold steady.
- R5: An output request that needs more free entries than the 8-entry transmit buffer has writes nothing and raises out_paused from the next cycle. Once there is room for the whole request, all of its tokens are written in one cycle, out_paused drops, and out_resume is high for exactly one cycle.
- R6: An out_req that arrives while out_paused is high is ignored: it enqueues nothing and produces no out_done.
- R7: The receive side accepts a token (rx_valid and rx_ready both high) while fewer than 8 tokens are buffered. When 8 tokens are buffered, rx_ready is low and offered tokens are not taken.
- R8: An in_req with in_word=0 that finds a token buffered removes it. In the next cycle in_done is high, in_data holds the payload zero-extended in bits [7:0], and in_ctrl holds its flag.
- R9: An in_req with in_word=1 that finds four data tokens removes them. in_data is assembled with the first token in bits [31:24] and the fourth in bits [7:0], and in_ctrl is 0.
- R10: An input request that finds too few tokens raises in_paused from the next cycle. Once enough tokens have arrived, it completes, in_paused drops, and in_resume is high for exactly one cycle, carrying the result.
- R11: A word input where any of the next min(buffered, 4) tokens is a control token completes with in_err high in the same cycle as in_done or in_resume. It consumes no tokens.
- R12: An in_req that arrives while in_paused is high is ignored: it consumes nothing and produces no in_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_req | input | 1 | Output request strobe from a thread |
| out_word | input | 1 | 1: whole word, 0: single token |
| out_ctrl | input | 1 | Control flag for a single-token output |
| out_data | input | 32 | Output word or token payload in [7:0] |
| out_done | output | 1 | Output completed without pausing |
| out_paused | output | 1 | Output thread paused |
| out_resume | output | 1 | Paused output has completed |
| tx_valid | output | 1 | Transmit token available |
| tx_ctrl | output | 1 | Transmit token control flag |
| tx_data | output | 8 | Transmit token payload |
| tx_ready | input | 1 | Link accepts transmit token |
| rx_valid | input | 1 | Receive token offered |
| rx_ctrl | input | 1 | Receive token control flag |
| rx_data | input | 8 | Receive token payload |
| rx_ready | output | 1 | Receive buffer has room |
| in_req | input | 1 | Input request strobe from a thread |
| in_word | input | 1 | 1: whole word, 0: single token |
| in_done | output | 1 | Input completed without pausing |
| in_resume | output | 1 | Paused input has completed |
| in_paused | output | 1 | Input thread paused |
| in_err | output | 1 | Word input blocked by a control token |
| in_ctrl | output | 1 | Control flag of a returned token |
| in_data | output | 32 | Returned word or token |

## Verification
Each of the two buffers can go wrong in its own way, and the ports show both.

A wrong fill level on the transmit side shows up within a cycle or two. It appears as a premature or missing pause, a resume that fires too early or never, or lost or repeated tokens on tx_data. The scoreboard sees these as an order mismatch or a leftover token.

A wrong read pointer or count on the receive side corrupts the next word assembled on in_data. It can also make rx_ready stay high while the buffer is full, and the extra token then surfaces at the next token input. A paused request that is not held shows as a missing resume, or as a duplicated result when a second request arrives during the pause.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam int TOK_W = 8;

  typedef struct packed {
    logic             ctrl;
    logic [TOK_W-1:0] data;
  } tok_t;
endpackage

// File: rtl/tce_fifo.sv
// Circular token buffer: multi-token push and pop, with a peek window at the head.
module tce_fifo
  import tce_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIN   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(WIN+1)-1:0]       push_n,
  input  tok_t [WIN-1:0]                 push_tok,
  input  logic [$clog2(WIN+1)-1:0]       pop_n,
  output tok_t [WIN-1:0]                 peek,
  output logic [$clog2(DEPTH+1)-1:0]     level
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  tok_t          mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] lvl_q, lvl_d;

  always_comb begin
    rd_d  = rd_q + PW'(pop_n);
    wr_d  = wr_q + PW'(push_n);
    lvl_d = lvl_q + CW'(push_n) - CW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  // storage carries no reset; entries are written before they are read
  always_ff @(posedge clk) begin
    for (int i = 0; i < WIN; i++) begin
      if (i < int'(push_n)) mem[wr_q + PW'(i)] <= push_tok[i];
    end
  end

  generate
    for (genvar g = 0; g < WIN; g++) begin : g_peek
      assign peek[g] = mem[rd_q + PW'(g)];
    end
  endgenerate

  assign level = lvl_q;
endmodule

// File: rtl/tce_tx_side.sv
// Output path: thread requests with pause/resume, transmit buffer, link handshake.
module tce_tx_side
  import tce_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       out_req,
  input  logic                       out_word,
  input  logic                       out_ctrl,
  input  logic [WORD_W-1:0]          out_data,
  output logic                       out_done,
  output logic                       out_paused,
  output logic                       out_resume,
  output logic                       tx_valid,
  output tok_t                       tx_tok,
  input  logic                       tx_ready,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int WIN = WORD_W / TOK_W;
  localparam int NW  = $clog2(WIN+1);
  localparam int CW  = $clog2(DEPTH+1);

  logic              pend_q, pend_d;
  logic              pw_q, pc_q;
  logic [WORD_W-1:0] pd_q;
  logic              done_q, done_d, res_q, res_d;

  logic              a_valid, a_word, a_ctrl;
  logic [WORD_W-1:0] a_data;
  logic [CW-1:0]     need, room;
  logic              fits, commit, capture;
  logic [NW-1:0]     push_n, pop_n;
  tok_t [WIN-1:0]    push_tok, peek;

  always_comb begin
    a_valid = pend_q | out_req;
    a_word  = pend_q ? pw_q : out_word;
    a_ctrl  = pend_q ? pc_q : out_ctrl;
    a_data  = pend_q ? pd_q : out_data;
    need    = a_word ? CW'(WIN) : CW'(1);
    room    = CW'(DEPTH) - level;
    fits    = room >= need;
    commit  = a_valid & fits;
    capture = ~pend_q & out_req & ~fits;
    push_n  = commit ? NW'(need) : '0;
    for (int i = 0; i < WIN; i++) begin
      if (a_word) begin
        push_tok[i].ctrl = 1'b0;
        push_tok[i].data = a_data[WORD_W-1-i*TOK_W -: TOK_W];
      end else begin
        push_tok[i].ctrl = a_ctrl;
        push_tok[i].data = a_data[TOK_W-1:0];
      end
    end
    pend_d = pend_q ? ~fits : capture;
    done_d = ~pend_q & out_req & fits;
    res_d  = pend_q & fits;
    pop_n  = (tx_valid & tx_ready) ? NW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q <= 1'b0;
      pc_q <= 1'b0;
      pd_q <= '0;
    end else if (capture) begin
      pw_q <= out_word;
      pc_q <= out_ctrl;
      pd_q <= out_data;
    end
  end

  tce_fifo #(.DEPTH(DEPTH), .WIN(WIN)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_tok(push_tok),
    .pop_n(pop_n), .peek(peek), .level(level)
  );

  assign tx_valid   = level != '0;
  assign tx_tok     = peek[0];
  assign out_done   = done_q;
  assign out_paused = pend_q;
  assign out_resume = res_q;
endmodule

// File: rtl/tce_rx_side.sv
// Input path: receive buffer, thread token/word reads with pause/resume and error check.
module tce_rx_side
  import tce_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  tok_t                       rx_tok,
  output logic                       rx_ready,
  input  logic                       in_req,
  input  logic                       in_word,
  output logic                       in_done,
  output logic                       in_resume,
  output logic                       in_paused,
  output logic                       in_err,
  output logic                       in_ctrl,
  output logic [WORD_W-1:0]          in_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int WIN = WORD_W / TOK_W;
  localparam int NW  = $clog2(WIN+1);
  localparam int CW  = $clog2(DEPTH+1);

  logic              pend_q, pend_d, pw_q;
  logic              done_q, done_d, res_q, res_d, err_q, err_d;
  logic              ctrl_q, ctrl_d;
  logic [WORD_W-1:0] data_q, data_d;

  logic              a_valid, a_word, seen_ctrl, enough, commit;
  logic [NW-1:0]     push_n, pop_n;
  tok_t [WIN-1:0]    push_tok, peek;

  always_comb begin
    rx_ready = level < CW'(DEPTH);
    push_n   = (rx_valid & rx_ready) ? NW'(1) : '0;
    push_tok = '0;
    push_tok[0] = rx_tok;

    seen_ctrl = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      if (CW'(i) < level && peek[i].ctrl) seen_ctrl = 1'b1;
    end

    a_valid = pend_q | in_req;
    a_word  = pend_q ? pw_q : in_word;
    enough  = a_word ? (level >= CW'(WIN) || seen_ctrl) : (level != '0);
    commit  = a_valid & enough;
    err_d   = commit & a_word & seen_ctrl;

    if (!commit || err_d) pop_n = '0;
    else                  pop_n = a_word ? NW'(WIN) : NW'(1);

    data_d = '0;
    ctrl_d = 1'b0;
    if (a_word) begin
      for (int i = 0; i < WIN; i++) data_d[WORD_W-1-i*TOK_W -: TOK_W] = peek[i].data;
    end else begin
      data_d[TOK_W-1:0] = peek[0].data;
      ctrl_d            = peek[0].ctrl;
    end

    pend_d = pend_q ? ~enough : (in_req & ~enough);
    done_d = ~pend_q & in_req & enough;
    res_d  = pend_q & enough;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      res_q  <= res_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pw_q <= 1'b0;
    else if (~pend_q & in_req)  pw_q <= in_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= 1'b0;
    end else if (commit) begin
      data_q <= data_d;
      ctrl_q <= ctrl_d;
    end
  end

  tce_fifo #(.DEPTH(DEPTH), .WIN(WIN)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_tok(push_tok),
    .pop_n(pop_n), .peek(peek), .level(level)
  );

  assign in_done   = done_q;
  assign in_resume = res_q;
  assign in_paused = pend_q;
  assign in_err    = err_q;
  assign in_ctrl   = ctrl_q;
  assign in_data   = data_q;
endmodule

// File: rtl/token_chan_end.sv
module token_chan_end
  import tce_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_req,
  input  logic              out_word,
  input  logic              out_ctrl,
  input  logic [WORD_W-1:0] out_data,
  output logic              out_done,
  output logic              out_paused,
  output logic              out_resume,
  output logic              tx_valid,
  output logic              tx_ctrl,
  output logic [TOK_W-1:0]  tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic              rx_ctrl,
  input  logic [TOK_W-1:0]  rx_data,
  output logic              rx_ready,
  input  logic              in_req,
  input  logic              in_word,
  output logic              in_done,
  output logic              in_resume,
  output logic              in_paused,
  output logic              in_err,
  output logic              in_ctrl,
  output logic [WORD_W-1:0] in_data
);
  localparam int CW = $clog2(DEPTH+1);

  tok_t          tx_tok, rx_tok;
  logic [CW-1:0] tx_level, rx_level;

  assign rx_tok.ctrl = rx_ctrl;
  assign rx_tok.data = rx_data;
  assign tx_ctrl     = tx_tok.ctrl;
  assign tx_data     = tx_tok.data;

  tce_tx_side #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .out_req(out_req), .out_word(out_word),
    .out_ctrl(out_ctrl), .out_data(out_data), .out_done(out_done),
    .out_paused(out_paused), .out_resume(out_resume), .tx_valid(tx_valid),
    .tx_tok(tx_tok), .tx_ready(tx_ready), .level(tx_level)
  );

  tce_rx_side #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_tok(rx_tok),
    .rx_ready(rx_ready), .in_req(in_req), .in_word(in_word),
    .in_done(in_done), .in_resume(in_resume), .in_paused(in_paused),
    .in_err(in_err), .in_ctrl(in_ctrl), .in_data(in_data), .level(rx_level)
  );
endmodule

// File: rtl/tce_checker.sv
module tce_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_done,
  input logic          out_paused,
  input logic          out_resume,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_ctrl,
  input logic [7:0]    tx_data,
  input logic          in_done,
  input logic          in_resume,
  input logic          in_paused,
  input logic          in_err,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level
);
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_ctrl));

  a_r5_out_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_resume |=> !out_resume);

  a_r5_out_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_paused) |-> out_resume);

  a_r5_tx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH));

  a_r6_no_done_while_paused: assert property (@(posedge clk) disable iff (!rst_n)
    out_paused |-> !out_done);

  a_r7_rx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(DEPTH));

  a_r10_in_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_resume |=> !in_resume);

  a_r10_in_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_paused) |-> in_resume);

  a_r11_err_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_err |-> (in_done || in_resume));

  a_r12_no_done_while_paused: assert property (@(posedge clk) disable iff (!rst_n)
    in_paused |-> !in_done);
endmodule

bind token_chan_end tce_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_done(out_done), .out_paused(out_paused),
  .out_resume(out_resume), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_ctrl(tx_ctrl), .tx_data(tx_data), .in_done(in_done),
  .in_resume(in_resume), .in_paused(in_paused), .in_err(in_err),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/token_chan_end_test.sv
module token_chan_end_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        out_req, out_word, out_ctrl;
  logic [31:0] out_data;
  logic        out_done, out_paused, out_resume;
  logic        tx_valid, tx_ctrl, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ctrl, rx_ready;
  logic [7:0]  rx_data;
  logic        in_req, in_word, in_done, in_resume, in_paused, in_err, in_ctrl;
  logic [31:0] in_data;

  token_chan_end uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [8:0]  txq[$];   // {ctrl, data}
  logic [34:0] inq[$];   // {resumed, err, ctrl, data}

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: samples 1 ns before each rising edge
  always begin
    @(negedge clk); #4;
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (txq.size() == 0) check(1'b0, "R2/R6 unexpected tx token", {23'd0, tx_ctrl, tx_data}, 32'h0);
        else begin
          logic [8:0] e;
          e = txq.pop_front();
          check({tx_ctrl, tx_data} == e, "R2/R3/R4 tx token order", {23'd0, tx_ctrl, tx_data}, {23'd0, e});
        end
      end
      if (in_done || in_resume) begin
        if (inq.size() == 0) check(1'b0, "R12 unexpected input result", in_data, 32'h0);
        else begin
          logic [34:0] e;
          e = inq.pop_front();
          check(in_resume == e[34], "R10 resume vs done", {31'd0, in_resume}, {31'd0, e[34]});
          check(in_err == e[33], "R11 error flag", {31'd0, in_err}, {31'd0, e[33]});
          if (!e[33]) begin
            check(in_ctrl == e[32], "R8 in_ctrl", {31'd0, in_ctrl}, {31'd0, e[32]});
            check(in_data == e[31:0], "R8/R9 in_data", in_data, e[31:0]);
          end
        end
      end
    end
  end

  task automatic do_out(input bit w, input bit c, input logic [31:0] d,
                        output bit done, output bit paused);
    @(negedge clk);
    out_req = 1'b1; out_word = w; out_ctrl = c; out_data = d;
    @(negedge clk);
    out_req = 1'b0;
    done = out_done; paused = out_paused;
  endtask

  task automatic do_in(input bit w, output bit done, output bit paused);
    @(negedge clk);
    in_req = 1'b1; in_word = w;
    @(negedge clk);
    in_req = 1'b0;
    done = in_done; paused = in_paused;
  endtask

  task automatic rx_send(input bit c, input logic [7:0] d);
    bit ok;
    @(negedge clk);
    rx_valid = 1'b1; rx_ctrl = c; rx_data = d;
    do begin
      #4 ok = rx_ready;
      @(negedge clk);
    end while (!ok);
    rx_valid = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) txq.push_back({1'b0, w[i*8 +: 8]});
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while ((inq.size() != 0 || txq.size() != 0) && t < 60) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    check(inq.size() == 0 && txq.size() == 0, req, inq.size() + txq.size(), 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit d, p;
    int t;
    rst_n = 1'b0; out_req = 0; out_word = 0; out_ctrl = 0; out_data = '0;
    tx_ready = 1'b1; rx_valid = 0; rx_ctrl = 0; rx_data = '0; in_req = 0; in_word = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({tx_valid, out_done, out_paused, out_resume, in_done, in_paused, in_resume, in_err} == 8'h0,
          "R1 outputs low in reset", {24'd0, tx_valid, out_done, out_paused, out_resume,
          in_done, in_paused, in_resume, in_err}, 32'h0);
    check(rx_ready == 1'b1, "R1 rx_ready in reset", {31'd0, rx_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 single control token out
    txq.push_back({1'b1, 8'hA5});
    do_out(1'b0, 1'b1, 32'h0000_00A5, d, p);
    check(d && !p, "R2 token out done", {30'd0, d, p}, 32'd2);
    // R3 word out, most significant byte first
    push_word(32'h1234_5678);
    do_out(1'b1, 1'b0, 32'h1234_5678, d, p);
    check(d && !p, "R3 word out done", {30'd0, d, p}, 32'd2);
    wait_drain("R2/R3 tx drained");

    // R4/R5/R6 backpressure, blocking and resume
    tx_ready = 1'b0;
    push_word(32'hCAFE_0001);
    do_out(1'b1, 1'b0, 32'hCAFE_0001, d, p);
    push_word(32'hCAFE_0002);
    do_out(1'b1, 1'b0, 32'hCAFE_0002, d, p);
    check(d && !p, "R5 buffer filled to 8", {30'd0, d, p}, 32'd2);
    push_word(32'hBEEF_0003);
    do_out(1'b1, 1'b0, 32'hBEEF_0003, d, p);
    check(!d && p, "R5 word out pauses when full", {30'd0, d, p}, 32'd1);
    do_out(1'b0, 1'b0, 32'h0000_0077, d, p);
    check(!d && p, "R6 request while paused ignored", {30'd0, d, p}, 32'd1);
    repeat (4) @(negedge clk);
    check(tx_valid && tx_data == 8'hCA, "R4 head held without ready", {23'd0, tx_valid, tx_data}, {23'd0, 9'h1CA});
    tx_ready = 1'b1;
    t = 0;
    while (!out_resume && t < 40) begin @(negedge clk); t++; end
    check(out_resume == 1'b1, "R5 out_resume after room", {31'd0, out_resume}, 32'd1);
    @(negedge clk);
    check(!out_resume && !out_paused, "R5 resume one cycle, pause cleared",
          {30'd0, out_resume, out_paused}, 32'd0);
    wait_drain("R5/R6 tx drained in order");

    // R10/R12 token input blocks, then resumes
    do_in(1'b0, d, p);
    check(!d && p, "R10 token in pauses when empty", {30'd0, d, p}, 32'd1);
    do_in(1'b0, d, p);
    check(!d && p, "R12 request while paused ignored", {30'd0, d, p}, 32'd1);
    inq.push_back({1'b1, 1'b0, 1'b0, 32'h0000_003C});
    rx_send(1'b0, 8'h3C);
    wait_drain("R10 token resume result");
    check(in_paused == 1'b0, "R10 pause cleared", {31'd0, in_paused}, 32'd0);

    // R9/R10 word input waits for four tokens
    inq.push_back({1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF});
    do_in(1'b1, d, p);
    check(!d && p, "R10 word in pauses", {30'd0, d, p}, 32'd1);
    rx_send(1'b0, 8'hDE); rx_send(1'b0, 8'hAD);
    rx_send(1'b0, 8'hBE); rx_send(1'b0, 8'hEF);
    wait_drain("R9 word assembled");

    // R11 control token blocks a word, nothing consumed; R8 tokens then read
    rx_send(1'b0, 8'h11);
    rx_send(1'b1, 8'h01);
    inq.push_back({1'b0, 1'b1, 1'b0, 32'h0});
    do_in(1'b1, d, p);
    check(d && !p, "R11 word in completes with error", {30'd0, d, p}, 32'd2);
    inq.push_back({1'b0, 1'b0, 1'b0, 32'h0000_0011});
    do_in(1'b0, d, p);
    inq.push_back({1'b0, 1'b0, 1'b1, 32'h0000_0001});
    do_in(1'b0, d, p);
    check(d, "R8 control token read", {31'd0, d}, 32'd1);
    wait_drain("R8/R11 results");

    // R7 fill receive buffer, extra token refused
    for (int i = 0; i < 8; i++) rx_send(1'b0, 8'h40 + 8'(i));
    @(negedge clk);
    check(rx_ready == 1'b0, "R7 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    rx_valid = 1'b1; rx_data = 8'h99; rx_ctrl = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_ready == 1'b0, "R7 still full under offer", {31'd0, rx_ready}, 32'd0);
    rx_valid = 1'b0;
    inq.push_back({1'b0, 1'b0, 1'b0, 32'h4041_4243});
    do_in(1'b1, d, p);
    inq.push_back({1'b0, 1'b0, 1'b0, 32'h4445_4647});
    do_in(1'b1, d, p);
    wait_drain("R7/R9 drained words");
    do_in(1'b0, d, p);
    check(!d && p, "R7 refused token was not stored", {30'd0, d, p}, 32'd1);
    inq.push_back({1'b1, 1'b0, 1'b0, 32'h0000_005A});
    rx_send(1'b0, 8'h5A);
    wait_drain("R7 final resume");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule